// File: doc/BRIEF.md
# Delayed Branch Next-PC Sequencer

This block keeps the program counter pair (PC and next PC) for a pipeline with one delay slot. Each cycle it resolves the decoded control-transfer request of the instruction at PC and sets the next pair. It also marks the following delay-slot instruction as annulled when that is needed. It reports a link-register write for call and jump-and-link, and it raises trap requests. An external evaluator supplies the taken decision for conditional branches and conditional traps. Instruction fetch, the register file and trap vectoring are outside the block. On a trap the block only reports the trap kind and the software trap number.

The controller has two states. RUN is the normal state, and the block stays in RUN while no trap is raised. On a trap raise the block goes from RUN to TRAP_HOLD. In TRAP_HOLD the PC pair is frozen, the trap pulse is shown and every request is ignored. The block then returns from TRAP_HOLD to RUN on the next edge without any condition. When the slot-annul flag is high, the instruction now at PC is cancelled. Its request is then treated as a plain sequential step: no link write, no trap and no redirect.

Top module: `dslot_seq`

## Requirements
- R1: While reset is active and right after it is released, PC is 0, next PC is 4, slot_annul is 0 and trap_valid is 0.
- R2: With xfer_op 0 (none) in RUN, on the edge PC takes the old next PC and next PC takes the old next PC plus 4.
- R3: A conditional branch (xfer_op 1) with cond_met high is taken. PC takes the old next PC, next PC takes PC plus rel_disp, and slot_annul is 0 whatever annul_req is.
- R4: A conditional branch with cond_met low is not taken. It follows the sequential step, and slot_annul takes annul_req.
- R5: Branch-always (xfer_op 2) redirects like a taken branch, and branch-never (xfer_op 3) steps sequentially. For both, slot_annul takes annul_req, so branch-always with annul_req cancels its delay instruction.
- R6: A call (xfer_op 4) redirects next PC to PC plus rel_disp. In the same cycle it raises link_we with link_reg equal to the fixed register 15 and link_val equal to the current PC.
- R7: Jump-and-link (xfer_op 5) with ind_addr[1:0] equal to 0 redirects next PC to ind_addr. In the same cycle it writes the current PC to register dest_reg.
- R8: Jump-and-link with ind_addr[1:0] nonzero raises a misaligned trap (trap_kind 1). It writes no link register and does not redirect.
- R9: A conditional trap (xfer_op 6) with cond_met high raises a software trap (trap_kind 2'd3, trap_code equal to soft_num). With cond_met low it steps sequentially.
- R10: Return-from-trap (xfer_op 7) with sup_mode low raises a privileged trap (trap_kind 2). This check takes priority over alignment. With sup_mode high and ind_addr misaligned it raises trap_kind 1. With sup_mode high and an aligned target it redirects next PC to ind_addr.
- R11: A raised trap enters TRAP_HOLD. trap_valid is high for exactly one cycle, and PC and next PC stay unchanged through that cycle and the following edge. A request presented during TRAP_HOLD has no effect. Outside TRAP_HOLD, trap_kind and trap_code read 0.
- R12: While slot_annul is high, the request at the ports is ignored. There is no link write and no trap, and the PC pair steps sequentially.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_op | input | 3 | Request kind: 0 none, 1 cond branch, 2 always, 3 never, 4 call, 5 jump-and-link, 6 cond trap, 7 return-from-trap |
| cond_met | input | 1 | Condition result from the external evaluator |
| annul_req | input | 1 | Annul option of the branch |
| sup_mode | input | 1 | Supervisor (privileged) mode bit |
| rel_disp | input | 32 | Signed byte displacement from PC |
| ind_addr | input | 32 | Register-computed target address |
| dest_reg | input | 5 | Link destination for jump-and-link |
| soft_num | input | 7 | Software trap number |
| pc | output | 32 | Current PC |
| npc | output | 32 | Next PC |
| slot_annul | output | 1 | Instruction at PC is annulled |
| link_we | output | 1 | Link register write enable (same cycle) |
| link_reg | output | 5 | Link register index |
| link_val | output | 32 | Value to link (current PC) |
| trap_valid | output | 1 | One-cycle trap pulse |
| trap_kind | output | 2 | 1 misaligned, 2 privileged, 3 software |
| trap_code | output | 7 | Software trap number when trap_kind is 3 |

## Verification
The link outputs depend only on the current request and the current state, so they are due in the same cycle as the request. The bench reads them one time unit after it drives the inputs on the falling edge, before the next rising edge. PC, next PC, slot_annul and the trap outputs each pass through one register. They are therefore checked at the falling edge that follows the rising edge which loads them. The reference model advances exactly once per edge. A trap costs one extra cycle in TRAP_HOLD, so the step after a trap is checked for frozen state and for an ignored request before the flow resumes.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_BCC  = 3'd1,
        OP_BA   = 3'd2,
        OP_BN   = 3'd3,
        OP_CALL = 3'd4,
        OP_JMPL = 3'd5,
        OP_TCC  = 3'd6,
        OP_RETT = 3'd7
    } xfer_op_t;

    typedef enum logic [1:0] {
        TK_NONE  = 2'd0,
        TK_ALIGN = 2'd1,
        TK_PRIV  = 2'd2,
        TK_SOFT  = 2'd3
    } trap_kind_t;

    typedef enum logic {
        ST_RUN       = 1'b0,
        ST_TRAP_HOLD = 1'b1
    } seq_state_t;

endpackage

// File: rtl/seq_target.sv
module seq_target #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] cur_pc,
    input  logic [AW-1:0] cur_npc,
    input  logic [AW-1:0] disp,
    input  logic [AW-1:0] reg_addr,
    output logic [AW-1:0] rel_target,
    output logic [AW-1:0] seq_target_o,
    output logic          reg_aligned
);
    localparam int            ALIGN_BITS = 2;
    localparam logic [AW-1:0] STEP_BYTES = AW'(4);

    always_comb begin
        rel_target   = cur_pc + disp;
        seq_target_o = cur_npc + STEP_BYTES;
        reg_aligned  = (reg_addr[ALIGN_BITS-1:0] == '0);
    end
endmodule

// File: rtl/seq_decide.sv
module seq_decide
    import seq_pkg::*;
#(
    parameter int RW       = 5,
    parameter int TW       = 7,
    parameter int LINK_REG = 15
) (
    input  logic       active,
    input  xfer_op_t   op,
    input  logic       cond,
    input  logic       annul_opt,
    input  logic       sup,
    input  logic       aligned,
    input  logic [RW-1:0] rd_in,
    input  logic [TW-1:0] num_in,
    output logic       redirect,
    output logic       use_reg,
    output logic       annul_next,
    output logic       lwe,
    output logic [RW-1:0] lrd,
    output logic       trap_req,
    output trap_kind_t tkind,
    output logic [TW-1:0] tnum
);
    always_comb begin
        redirect   = 1'b0;
        use_reg    = 1'b0;
        annul_next = 1'b0;
        lwe        = 1'b0;
        lrd        = '0;
        trap_req   = 1'b0;
        tkind      = TK_NONE;
        tnum       = '0;
        if (active) begin
            unique case (op)
                OP_NONE: ;
                OP_BCC: begin
                    redirect   = cond;
                    annul_next = annul_opt & ~cond;
                end
                OP_BA: begin
                    redirect   = 1'b1;
                    annul_next = annul_opt;
                end
                OP_BN: annul_next = annul_opt;
                OP_CALL: begin
                    redirect = 1'b1;
                    lwe      = 1'b1;
                    lrd      = RW'(LINK_REG);
                end
                OP_JMPL: begin
                    if (aligned) begin
                        redirect = 1'b1;
                        use_reg  = 1'b1;
                        lwe      = 1'b1;
                        lrd      = rd_in;
                    end else begin
                        trap_req = 1'b1;
                        tkind    = TK_ALIGN;
                    end
                end
                OP_TCC: begin
                    if (cond) begin
                        trap_req = 1'b1;
                        tkind    = TK_SOFT;
                        tnum     = num_in;
                    end
                end
                OP_RETT: begin
                    if (!sup) begin
                        trap_req = 1'b1;
                        tkind    = TK_PRIV;
                    end else if (!aligned) begin
                        trap_req = 1'b1;
                        tkind    = TK_ALIGN;
                    end else begin
                        redirect = 1'b1;
                        use_reg  = 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/dslot_seq.sv
module dslot_seq
    import seq_pkg::*;
#(
    parameter int AW       = 32,
    parameter int RW       = 5,
    parameter int TW       = 7,
    parameter int LINK_REG = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    xfer_op,
    input  logic          cond_met,
    input  logic          annul_req,
    input  logic          sup_mode,
    input  logic [AW-1:0] rel_disp,
    input  logic [AW-1:0] ind_addr,
    input  logic [RW-1:0] dest_reg,
    input  logic [TW-1:0] soft_num,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] npc,
    output logic          slot_annul,
    output logic          link_we,
    output logic [RW-1:0] link_reg,
    output logic [AW-1:0] link_val,
    output logic          trap_valid,
    output logic [1:0]    trap_kind,
    output logic [TW-1:0] trap_code
);
    localparam logic [AW-1:0] RESET_NPC = AW'(4);

    seq_state_t    state_q, state_d;
    logic [AW-1:0] pc_q, pc_d, npc_q, npc_d;
    logic          annul_q, annul_d;
    trap_kind_t    tk_q, tk_d;
    logic [TW-1:0] tn_q, tn_d;

    logic [AW-1:0] rel_t, seq_t;
    logic          aligned;
    logic          active;
    logic          redirect, use_reg, annul_next, lwe, trap_req;
    logic [RW-1:0] lrd;
    trap_kind_t    tkind;
    logic [TW-1:0] tnum;

    assign active = (state_q == ST_RUN) && !annul_q;

    seq_target #(.AW(AW)) u_tgt (
        .cur_pc       (pc_q),
        .cur_npc      (npc_q),
        .disp         (rel_disp),
        .reg_addr     (ind_addr),
        .rel_target   (rel_t),
        .seq_target_o (seq_t),
        .reg_aligned  (aligned)
    );

    seq_decide #(.RW(RW), .TW(TW), .LINK_REG(LINK_REG)) u_dec (
        .active     (active),
        .op         (xfer_op_t'(xfer_op)),
        .cond       (cond_met),
        .annul_opt  (annul_req),
        .sup        (sup_mode),
        .aligned    (aligned),
        .rd_in      (dest_reg),
        .num_in     (soft_num),
        .redirect   (redirect),
        .use_reg    (use_reg),
        .annul_next (annul_next),
        .lwe        (lwe),
        .lrd        (lrd),
        .trap_req   (trap_req),
        .tkind      (tkind),
        .tnum       (tnum)
    );

    always_comb begin
        state_d = state_q;
        pc_d    = pc_q;
        npc_d   = npc_q;
        annul_d = 1'b0;
        tk_d    = TK_NONE;
        tn_d    = '0;
        unique case (state_q)
            ST_RUN: begin
                if (trap_req) begin
                    state_d = ST_TRAP_HOLD;
                    tk_d    = tkind;
                    tn_d    = tnum;
                end else begin
                    pc_d    = npc_q;
                    npc_d   = redirect ? (use_reg ? ind_addr : rel_t) : seq_t;
                    annul_d = annul_next;
                end
            end
            ST_TRAP_HOLD: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            pc_q    <= '0;
            npc_q   <= RESET_NPC;
            annul_q <= 1'b0;
            tk_q    <= TK_NONE;
            tn_q    <= '0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
            npc_q   <= npc_d;
            annul_q <= annul_d;
            tk_q    <= tk_d;
            tn_q    <= tn_d;
        end
    end

    always_comb begin
        pc         = pc_q;
        npc        = npc_q;
        slot_annul = annul_q;
        link_we    = lwe;
        link_reg   = lrd;
        link_val   = pc_q;
        trap_valid = (state_q == ST_TRAP_HOLD);
        trap_kind  = tk_q;
        trap_code  = tn_q;
    end
endmodule

// File: rtl/dslot_seq_chk.sv
module dslot_seq_chk #(
    parameter int AW = 32,
    parameter int RW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    xfer_op,
    input logic          cond_met,
    input logic          annul_req,
    input logic [AW-1:0] pc,
    input logic [AW-1:0] npc,
    input logic          slot_annul,
    input logic          link_we,
    input logic [RW-1:0] link_reg,
    input logic [AW-1:0] link_val,
    input logic          trap_valid,
    input logic [1:0]    trap_kind
);
    // R1
    reset_state_chk: assert property (@(posedge clk) !rst_n |=> (pc == '0 && npc == AW'(4) && !slot_annul && !trap_valid));

    // R2
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_op == 3'd0 && !trap_valid) |=> (pc == $past(npc) && npc == $past(npc) + AW'(4)));

    // R3
    taken_keeps_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_op == 3'd1 && cond_met && !slot_annul && !trap_valid) |=> (!slot_annul && pc == $past(npc)));

    // R5
    always_annul_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_op == 3'd2 && annul_req && !slot_annul && !trap_valid) |=> slot_annul);

    // R6
    call_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_op == 3'd4 && !slot_annul && !trap_valid) |-> (link_we && link_reg == RW'(15) && link_val == pc));

    // R11
    trap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |=> !trap_valid);

    // R11
    trap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> (pc == $past(pc) && npc == $past(npc) && trap_kind != 2'd0 && !link_we));

    // R12
    annul_no_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_annul |-> !link_we);

    // R12
    annul_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_annul |=> !trap_valid);
endmodule

bind dslot_seq dslot_seq_chk #(.AW(AW), .RW(RW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_op    (xfer_op),
    .cond_met   (cond_met),
    .annul_req  (annul_req),
    .pc         (pc),
    .npc        (npc),
    .slot_annul (slot_annul),
    .link_we    (link_we),
    .link_reg   (link_reg),
    .link_val   (link_val),
    .trap_valid (trap_valid),
    .trap_kind  (trap_kind)
);

// File: tb/sim_dslot_seq.sv
`timescale 1ns/1ps
module sim_dslot_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  xfer_op = '0;
    logic        cond_met = 1'b0, annul_req = 1'b0, sup_mode = 1'b0;
    logic [31:0] rel_disp = '0, ind_addr = '0;
    logic [4:0]  dest_reg = '0;
    logic [6:0]  soft_num = '0;
    logic [31:0] pc, npc, link_val;
    logic        slot_annul, link_we, trap_valid;
    logic [4:0]  link_reg;
    logic [1:0]  trap_kind;
    logic [6:0]  trap_code;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [31:0] m_pc, m_npc;
    logic        m_an, m_tv;
    logic [1:0]  m_tk;
    logic [6:0]  m_tn;

    always #5 clk = ~clk;

    dslot_seq u0 (
        .clk(clk), .rst_n(rst_n), .xfer_op(xfer_op), .cond_met(cond_met),
        .annul_req(annul_req), .sup_mode(sup_mode), .rel_disp(rel_disp),
        .ind_addr(ind_addr), .dest_reg(dest_reg), .soft_num(soft_num),
        .pc(pc), .npc(npc), .slot_annul(slot_annul), .link_we(link_we),
        .link_reg(link_reg), .link_val(link_val), .trap_valid(trap_valid),
        .trap_kind(trap_kind), .trap_code(trap_code)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_regs(input string tag);
        chk(tag, "pc", pc, m_pc);
        chk(tag, "npc", npc, m_npc);
        chk(tag, "slot_annul", 32'(slot_annul), 32'(m_an));
        chk(tag, "trap_valid", 32'(trap_valid), 32'(m_tv));
        chk(tag, "trap_kind", 32'(trap_kind), 32'(m_tk));
        chk(tag, "trap_code", 32'(trap_code), 32'(m_tn));
    endtask

    task automatic step(input logic [2:0] o, input logic c, input logic a, input logic s,
                        input logic [31:0] d, input logic [31:0] r, input logic [4:0] rd,
                        input logic [6:0] tn, input string tag);
        logic        e_we;
        logic [4:0]  e_rd;
        logic [31:0] n_pc, n_npc;
        logic        n_an, n_tv;
        logic [1:0]  n_tk;
        logic [6:0]  n_tn;
        xfer_op = o; cond_met = c; annul_req = a; sup_mode = s;
        rel_disp = d; ind_addr = r; dest_reg = rd; soft_num = tn;
        e_we = 1'b0; e_rd = '0;
        n_pc = m_npc; n_npc = m_npc + 32'd4; n_an = 1'b0;
        n_tv = 1'b0; n_tk = 2'd0; n_tn = '0;
        if (m_tv) begin
            n_pc = m_pc; n_npc = m_npc;
        end else if (!m_an) begin
            case (o)
                3'd1: if (c) n_npc = m_pc + d; else n_an = a;
                3'd2: begin n_npc = m_pc + d; n_an = a; end
                3'd3: n_an = a;
                3'd4: begin n_npc = m_pc + d; e_we = 1'b1; e_rd = 5'd15; end
                3'd5: if (r[1:0] == 2'b00) begin
                          n_npc = r; e_we = 1'b1; e_rd = rd;
                      end else begin
                          n_tv = 1'b1; n_tk = 2'd1;
                      end
                3'd6: if (c) begin n_tv = 1'b1; n_tk = 2'd3; n_tn = tn; end
                3'd7: if (!s) begin n_tv = 1'b1; n_tk = 2'd2; end
                      else if (r[1:0] != 2'b00) begin n_tv = 1'b1; n_tk = 2'd1; end
                      else n_npc = r;
                default: ;
            endcase
            if (n_tv) begin n_pc = m_pc; n_npc = m_npc; end
        end
        #1;
        chk(tag, "link_we", 32'(link_we), 32'(e_we));
        if (e_we) begin
            chk(tag, "link_reg", 32'(link_reg), 32'(e_rd));
            chk(tag, "link_val", link_val, m_pc);
        end
        @(posedge clk);
        m_pc = n_pc; m_npc = n_npc; m_an = n_an; m_tv = n_tv; m_tk = n_tk; m_tn = n_tn;
        @(negedge clk);
        check_regs(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog all-requirements actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        m_pc = '0; m_npc = 32'd4; m_an = 1'b0; m_tv = 1'b0; m_tk = '0; m_tn = '0;
        repeat (3) @(negedge clk);
        check_regs("R1");
        rst_n = 1'b1;
        @(negedge clk);
        m_pc = 32'd4; m_npc = 32'd8;
        check_regs("R1");
        step(3'd0, 0, 0, 0, 0, 0, 0, 0, "R2");
        step(3'd0, 1, 1, 1, 32'h40, 0, 0, 0, "R2");
        // R3: taken with annul set keeps the slot
        step(3'd1, 1, 1, 0, 32'h100, 0, 0, 0, "R3");
        step(3'd0, 0, 0, 0, 0, 0, 0, 0, "R3");
        step(3'd1, 1, 0, 0, 32'hFFFF_FFF8, 0, 0, 0, "R3");
        step(3'd0, 0, 0, 0, 0, 0, 0, 0, "R3");
        // R4: untaken with annul, then R12 on the cancelled call
        step(3'd1, 0, 1, 0, 32'h80, 0, 0, 0, "R4");
        step(3'd4, 0, 0, 0, 32'h200, 0, 0, 0, "R12");
        step(3'd1, 0, 0, 0, 32'h80, 0, 0, 0, "R4");
        // R5: always with annul cancels slot even though taken
        step(3'd2, 0, 1, 0, 32'h300, 0, 0, 0, "R5");
        step(3'd6, 1, 0, 0, 0, 0, 0, 7'h22, "R12");
        step(3'd3, 1, 1, 0, 32'h300, 0, 0, 0, "R5");
        step(3'd0, 0, 0, 0, 0, 0, 0, 0, "R5");
        step(3'd3, 1, 0, 0, 32'h300, 0, 0, 0, "R5");
        step(3'd2, 0, 0, 0, 32'h10, 0, 0, 0, "R5");
        step(3'd0, 0, 0, 0, 0, 0, 0, 0, "R5");
        // R6 and R7
        step(3'd4, 0, 1, 0, 32'h1000, 0, 0, 0, "R6");
        step(3'd0, 0, 0, 0, 0, 0, 0, 0, "R6");
        step(3'd5, 0, 0, 0, 0, 32'h0000_2000, 5'd9, 0, "R7");
        step(3'd0, 0, 0, 0, 0, 0, 0, 0, "R7");
        // R8 then R11: request during hold is ignored
        step(3'd5, 0, 0, 0, 0, 32'h0000_2002, 5'd3, 0, "R8");
        step(3'd4, 0, 0, 0, 32'h40, 0, 0, 0, "R11");
        step(3'd0, 0, 0, 0, 0, 0, 0, 0, "R11");
        // R9
        step(3'd6, 1, 0, 0, 0, 0, 0, 7'h55, "R9");
        step(3'd0, 0, 0, 0, 0, 0, 0, 0, "R11");
        step(3'd6, 0, 0, 0, 0, 0, 0, 7'h55, "R9");
        // R10
        step(3'd7, 0, 0, 0, 0, 32'h0000_3001, 0, 0, "R10");
        step(3'd0, 0, 0, 0, 0, 0, 0, 0, "R10");
        step(3'd7, 0, 0, 1, 0, 32'h0000_3001, 0, 0, "R10");
        step(3'd0, 0, 0, 0, 0, 0, 0, 0, "R10");
        step(3'd7, 0, 0, 1, 0, 32'h0000_3000, 0, 0, "R10");
        step(3'd0, 0, 0, 0, 0, 0, 0, 0, "R10");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule